// File: doc/BRIEF.md
# Shadowed-Period Timer Counter

This block is a free-running timer counter of parameterised width (24 bits by default) with a double-buffered period. In periodic mode the count climbs by one each clock from zero to the active period value and then returns to zero, so one period lasts period+1 clocks. Software never writes the period in the middle of a cycle. It writes a pending period instead, and the counter takes that value into its active period only at the edge where the count wraps back to zero. This lets a PWM or tick generator change its period without a truncated or stretched cycle. Re-enabling the timer from the disabled state does not take the pending value.

In position mode the counter tracks a shaft encoder. An external decoder supplies single-cycle up and down step pulses and an index pulse. Each step moves the count by one, modulo 2^width. The index pulse reloads the count from the pending register. Software may also preset the count directly. In this mode the pending value never moves into the active period.

Software reaches the block through a simple register write/read port. A sticky target flag records each wrap. The flag can be cleared by accessing the pending period through one of its two addresses. The other address reaches the same pending register without touching the flag.

Top module: `shadow_period_timer`

## Requirements
- R1: Reset (async assert of `rst_n`) forces count, active period, pending period and target flag to zero at once.
- R2: In periodic mode (`mode_i` = 2'b01), the count advances by one per clock. At the edge where the count equals the active period, it goes to zero.
- R3: The target flag is set at the wrap edge of R2, so it is seen together with the zero count. When a set and a clear arrive at the same edge, the set wins.
- R4: At the wrap edge of R2, the pending period is copied into the active period.
- R5: With `mode_i` = 2'b00 (or 2'b11), the count is forced to zero and held there. A later restart in periodic mode does not copy the pending period.
- R6: Register map (3-bit address): 0 = count, 1 = active period, 2 = pending period that clears the flag, 3 = pending period that keeps the flag. A write to 1 sets the active period. A write to 2 or 3 sets the pending period. Any read strobe or write to address 2 clears the flag, and address 3 leaves it alone. Addresses 4 to 7 read as zero.
- R7: In position mode (`mode_i` = 2'b10), an up step adds one and a down step subtracts one, modulo 2^24. An up and a down step in the same cycle cancel.
- R8: In position mode, an index pulse loads the count from the pending period. A software count write takes priority over the index pulse, and the index pulse takes priority over steps.
- R9: In position mode, the active period never changes except by a software write to address 1. This holds even when the count passes through zero.
- R10: A software write to the count (address 0) takes effect only in position mode. In other modes it is ignored.
- R11: `zero_o` is high exactly when the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | 00 off, 01 periodic, 10 position, 11 off |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects only) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Register read data for `reg_addr_i` |
| step_up_i | input | 1 | Position-mode up step pulse |
| step_dn_i | input | 1 | Position-mode down step pulse |
| index_i | input | 1 | Position-mode index pulse |
| count_o | output | 24 | Current count |
| tgt_flag_o | output | 1 | Sticky target-reached flag |
| zero_o | output | 1 | Count is zero |

## Verification
A wrong active period shows on `count_o` as a wrap at the wrong value within one period, and `tgt_flag_o` rises on a different clock. A shadow copy made at the wrong time, for example on a restart or in position mode, is caught when address 1 is read back right after that event, before any later wrap could hide it. A counter next-state error in position mode shows on `count_o` on the very next clock, because each step, index pulse or preset is checked one edge after it is applied.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_UP   = 2'b01,
    TM_QUAD = 2'b10,
    TM_RSVD = 2'b11
  } tmr_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_COUNT    = 3'd0;
  localparam logic [ADDR_W-1:0] A_ACTIVE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEND_CLR = 3'd2;
  localparam logic [ADDR_W-1:0] A_PEND_KEEP = 3'd3;
endpackage

// File: rtl/spt_reset_sync.sv
module spt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spt_count_core.sv
module spt_count_core
  import spt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] active_i,
  input  logic [CNT_W-1:0] pend_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             idx_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wrap_o = (mode_i == TM_UP) && (cnt_q == active_i);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    unique case (mode_i)
      TM_UP: begin
        cnt_d = wrap_o ? '0 : cnt_q + ONE;
      end
      TM_QUAD: begin
        cnt_en = cnt_wr_i | idx_i | (up_i ^ dn_i);
        if (cnt_wr_i)           cnt_d = cnt_wdata_i;
        else if (idx_i)         cnt_d = pend_i;
        else if (up_i && !dn_i) cnt_d = cnt_q + ONE;
        else if (dn_i && !up_i) cnt_d = cnt_q - ONE;
        else                    cnt_d = cnt_q;
      end
      default: begin
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_off_holds_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TM_OFF) |=> (cnt_q == '0));

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == TM_UP) && (cnt_q == active_i)) |=> (cnt_q == '0));

  assert_step_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == TM_QUAD) && up_i && dn_i && !idx_i && !cnt_wr_i) |=> $stable(cnt_q));

  assert_index_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == TM_QUAD) && idx_i && !cnt_wr_i) |=> (cnt_q == $past(pend_i)));
endmodule

// File: rtl/spt_period_shadow.sv
module spt_period_shadow
  import spt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_i,
  input  logic             wrap_i,
  input  logic             act_wr_i,
  input  logic             pend_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] active_o,
  output logic [CNT_W-1:0] pend_o
);
  logic [CNT_W-1:0] act_q, act_d, pend_q;
  logic             act_en;

  always_comb begin
    act_en = act_wr_i | wrap_i;
    act_d  = act_wr_i ? wdata_i : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= '0;
    else if (pend_wr_i) pend_q <= wdata_i;
  end

  assign active_o = act_q;
  assign pend_o   = pend_q;

  assert_copy_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !act_wr_i) |=> (act_q == $past(pend_q)));

  assert_no_copy_quad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == TM_QUAD) && !act_wr_i) |=> $stable(act_q));

  assert_no_copy_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == TM_OFF) && !act_wr_i) |=> $stable(act_q));
endmodule

// File: rtl/spt_flag_unit.sv
module spt_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/shadow_period_timer.sv
module shadow_period_timer
  import spt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             index_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tgt_flag_o,
  output logic             zero_o
);
  logic             rst_int_n;
  tmr_mode_e        mode;
  logic [CNT_W-1:0] active, pending, count;
  logic             wrap, act_wr, pend_wr, cnt_wr, flag_clr;

  assign mode = tmr_mode_e'(mode_i);

  spt_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  always_comb begin
    act_wr   = reg_wr_i && (reg_addr_i == A_ACTIVE);
    pend_wr  = reg_wr_i && ((reg_addr_i == A_PEND_CLR) || (reg_addr_i == A_PEND_KEEP));
    cnt_wr   = reg_wr_i && (reg_addr_i == A_COUNT) && (mode == TM_QUAD);
    flag_clr = (reg_wr_i || reg_rd_i) && (reg_addr_i == A_PEND_CLR);
  end

  spt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode),
    .active_i(active), .pend_i(pending),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(reg_wdata_i),
    .up_i(step_up_i), .dn_i(step_dn_i), .idx_i(index_i),
    .count_o(count), .wrap_o(wrap)
  );

  spt_period_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode), .wrap_i(wrap),
    .act_wr_i(act_wr), .pend_wr_i(pend_wr), .wdata_i(reg_wdata_i),
    .active_o(active), .pend_o(pending)
  );

  spt_flag_unit u_flag (
    .clk(clk), .rst_n(rst_int_n), .set_i(wrap), .clr_i(flag_clr),
    .flag_o(tgt_flag_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_COUNT:                 reg_rdata_o = count;
      A_ACTIVE:                reg_rdata_o = active;
      A_PEND_CLR, A_PEND_KEEP: reg_rdata_o = pending;
      default:                 reg_rdata_o = '0;
    endcase
  end

  assign count_o = count;
  assign zero_o  = (count == '0);

  assert_ignored_count_write_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode == TM_UP) && reg_wr_i && (reg_addr_i == A_COUNT) && (count != active))
      |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/sim_shadow_period_timer.sv
module sim_shadow_period_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata, count;
  logic        up = 1'b0, dn = 1'b0, idx = 1'b0;
  logic        flag, zero;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shadow_period_timer u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .step_up_i(up), .step_dn_i(dn), .index_i(idx),
    .count_o(count), .tgt_flag_o(flag), .zero_o(zero)
  );

  // {wr, addr[2:0], data[23:0], up, dn, idx, expected count[23:0]}
  localparam int NV = 12;
  localparam logic [54:0] QV [NV] = '{
    {1'b1, 3'd0, 24'd10,  1'b0, 1'b0, 1'b0, 24'd10},
    {1'b0, 3'd0, 24'd0,   1'b1, 1'b0, 1'b0, 24'd11},
    {1'b0, 3'd0, 24'd0,   1'b1, 1'b0, 1'b0, 24'd12},
    {1'b0, 3'd0, 24'd0,   1'b0, 1'b1, 1'b0, 24'd11},
    {1'b0, 3'd0, 24'd0,   1'b1, 1'b1, 1'b0, 24'd11},
    {1'b0, 3'd0, 24'd0,   1'b0, 1'b0, 1'b1, 24'd100},
    {1'b0, 3'd0, 24'd0,   1'b0, 1'b1, 1'b0, 24'd99},
    {1'b1, 3'd0, 24'd0,   1'b0, 1'b0, 1'b0, 24'd0},
    {1'b0, 3'd0, 24'd0,   1'b0, 1'b1, 1'b0, 24'hFFFFFF},
    {1'b0, 3'd0, 24'd0,   1'b1, 1'b0, 1'b0, 24'd0},
    {1'b0, 3'd0, 24'd0,   1'b1, 1'b0, 1'b1, 24'd100},
    {1'b1, 3'd0, 24'd5,   1'b0, 1'b0, 1'b1, 24'd5}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [23:0] d);
    wr = 1'b1; addr = a; wdata = d;
    cyc();
    wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [23:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    repeat (3) cyc();
    chk("R1 count in reset", count, 24'd0);
    chk("R1 flag in reset", {23'd0, flag}, 24'd0);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R11 zero after reset", {23'd0, zero}, 24'd1);

    reg_write(3'd1, 24'd3);
    reg_write(3'd3, 24'd5);
    peek(3'd1, v); chk("R6 active readback", v, 24'd3);
    peek(3'd2, v); chk("R6 pending readback", v, 24'd5);
    peek(3'd6, v); chk("R6 unused address", v, 24'd0);

    mode = 2'b01;
    cyc(); chk("R2 count step 1", count, 24'd1);
    cyc(); cyc();
    chk("R2 count reaches target", count, 24'd3);
    chk("R3 flag before wrap", {23'd0, flag}, 24'd0);
    peek(3'd1, v); chk("R4 active before wrap", v, 24'd3);
    cyc();
    chk("R2 wrap to zero", count, 24'd0);
    chk("R3 flag at wrap", {23'd0, flag}, 24'd1);
    peek(3'd1, v); chk("R4 pending adopted at wrap", v, 24'd5);

    rd = 1'b1; addr = 3'd3; cyc(); rd = 1'b0;
    chk("R6 keep-address read leaves flag", {23'd0, flag}, 24'd1);
    rd = 1'b1; addr = 3'd2; cyc(); rd = 1'b0;
    chk("R6 clear-address read clears flag", {23'd0, flag}, 24'd0);
    chk("R2 count after clears", count, 24'd2);

    reg_write(3'd0, 24'h000123);
    chk("R10 count write ignored in periodic", count, 24'd3);
    reg_write(3'd3, 24'd7);
    chk("R2 count 4", count, 24'd4);

    mode = 2'b00;
    cyc();
    chk("R5 off forces zero", count, 24'd0);
    chk("R11 zero flag high", {23'd0, zero}, 24'd1);
    cyc();
    chk("R5 off holds zero", count, 24'd0);
    peek(3'd1, v); chk("R5 no copy when stopped", v, 24'd5);

    mode = 2'b01;
    repeat (5) cyc();
    chk("R2 count at restarted target", count, 24'd5);
    chk("R11 zero flag low", {23'd0, zero}, 24'd0);
    peek(3'd1, v); chk("R5 no copy on restart", v, 24'd5);
    rd = 1'b1; addr = 3'd2; cyc(); rd = 1'b0;
    chk("R3 set wins over clear", {23'd0, flag}, 24'd1);
    peek(3'd1, v); chk("R4 new period adopted", v, 24'd7);

    reg_write(3'd2, 24'd100);
    chk("R6 clear-address write clears flag", {23'd0, flag}, 24'd0);

    mode = 2'b10;
    for (int i = 0; i < NV; i++) begin
      wr = QV[i][54]; addr = QV[i][53:51]; wdata = QV[i][50:27];
      up = QV[i][26]; dn = QV[i][25]; idx = QV[i][24];
      cyc();
      wr = 1'b0; up = 1'b0; dn = 1'b0; idx = 1'b0;
      chk($sformatf("R7/R8/R10 position vector %0d", i), count, QV[i][23:0]);
    end
    peek(3'd1, v); chk("R9 active unchanged in position mode", v, 24'd7);
    peek(3'd3, v); chk("R8 pending unchanged by index", v, 24'd100);
    chk("R3 no flag in position mode", {23'd0, flag}, 24'd0);

    rst_n = 1'b0;
    #1;
    chk("R1 async reset count", count, 24'd0);
    peek(3'd1, v); chk("R1 async reset active", v, 24'd0);
    peek(3'd3, v); chk("R1 async reset pending", v, 24'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule